// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block gathers stores aimed at write-combining memory into a small pool of line buffers so that the bus sees a few wide, byte-masked writes instead of many narrow ones. Each buffer owns one 64-byte aligned line. It keeps a valid flag for every byte of the line and a copy of the newest data for each byte. A store carries a word address (8-byte granularity), eight data bytes and eight byte enables. It either merges into the buffer that already owns its line or opens a free buffer. If no buffer is free, it waits while the oldest-opened buffer is written out.

A buffer leaves for the bus in three cases: all 64 of its bytes are valid, another line needs its slot, or a flush command asks for every occupied buffer to drain. The bus port offers one write at a time with a valid/ready handshake. Each write carries the line address, the full line of data, a 64-bit byte mask and a flag that marks a complete line. Writes from different lines carry no ordering promise. Nothing held here is ever visible to a data cache.

Top module: `wcb_store_buffer`

## Requirements
- R1: After reset no bus write is offered, `flush_done` is low and the store port is ready.
- R2: Stores to a line that already owns a buffer merge into it, so several stores to one line leave as exactly one bus write.
- R3: When two stores cover the same byte, the bus write carries the value of the later store for that byte.
- R4: A buffer whose 64 byte-valid flags are all set drains without any flush or eviction pressure, with `bw_full` high and every mask bit set.
- R5: The byte mask of every bus write equals exactly the set of bytes stored to that line since its buffer was opened. Mask bit n covers byte n of the line and data bits [8n+7:8n].
- R6: A store to a new line that finds all buffers occupied is held (`st_ready` low) until a buffer drains, and the buffer drained for it is the oldest-opened one.
- R7: A flush drains every occupied buffer. `st_ready` stays low from the cycle after `flush_req` until the flush completes. `flush_done` pulses for one cycle once no buffer is occupied and no write is pending.
- R8: While `bw_valid` is high and `bw_ready` is low, the address, mask and data of the offered write hold steady. The buffer is emptied in the cycle the write is accepted, and a later store to that line starts a fresh buffer.
- R9: A store whose byte enables are all zero is accepted and changes nothing, so it produces no bus write.
- R10: A store to the line whose buffer is currently being offered on the bus is held until that write is accepted.
- R11: Every bus write address is 64-byte aligned. Store enable bit b covers byte 8*w+b of the line, where w is the low three bits of `st_waddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high together with `st_valid` |
| st_waddr | input | ADDR_W-3 | Store word address (byte address divided by 8) |
| st_data | input | 64 | Store data, byte b in bits [8b+7:8b] |
| st_be | input | 8 | Store byte enables |
| flush_req | input | 1 | One-cycle request to drain all buffers |
| flush_done | output | 1 | One-cycle pulse when a flush has completed |
| bw_valid | output | 1 | Bus write offered |
| bw_ready | input | 1 | Bus accepts the offered write |
| bw_addr | output | ADDR_W | Line-aligned byte address of the write |
| bw_data | output | 512 | Line data, byte n in bits [8n+7:8n] |
| bw_mask | output | 64 | Byte mask of the write |
| bw_full | output | 1 | All 64 bytes of the line are valid |

## Verification
The hardest case to reach from the ports is a store that targets the very line whose buffer is already being offered on the bus. A buffer is offered only for a few cycles, so that store has to land inside that short window. The bench holds `bw_ready` low, fills one line completely so that it is offered as a full write, and then stores to that line while the write is still parked. This shows that the store waits, that the parked payload does not move, and that after acceptance the line reopens with only the new bytes. Eviction order is reached by opening all four buffers in a known order and then touching a fifth line.

// File: rtl/wcb_pkg.sv
// Shared constants and merge helper for the write-combining store buffer.
// Assumes a fixed 64-byte line and an 8-byte store word.
package wcb_pkg;
    localparam int LINE_BYTES = 64;
    localparam int WORD_BYTES = 8;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int WORD_OFS_W = $clog2(WORD_BYTES);
    localparam int WSEL_W     = OFS_W - WORD_OFS_W;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int WORD_W     = WORD_BYTES * 8;

    typedef struct packed {
        logic [LINE_BYTES-1:0] mask;
        logic [LINE_W-1:0]     data;
    } line_t;

    // Merge one store word into a line image; enabled bytes replace old ones.
    function automatic line_t merge_word(input line_t cur, input logic [WSEL_W-1:0] word,
                                         input logic [WORD_W-1:0] wdata,
                                         input logic [WORD_BYTES-1:0] be);
        line_t nxt;
        int unsigned pos;
        nxt = cur;
        for (int b = 0; b < WORD_BYTES; b++) begin
            pos = int'(word) * WORD_BYTES + b;
            if (be[b]) begin
                nxt.mask[pos]       = 1'b1;
                nxt.data[pos*8 +: 8] = wdata[b*8 +: 8];
            end
        end
        return nxt;
    endfunction
endpackage

// File: rtl/wcb_line.sv
// One line buffer: a tag, per-byte valid flags and line data.
// Assumes the caller never writes and clears the same buffer in one cycle;
// clear wins if both occur. Data is not reset; only masked bytes matter.
module wcb_line
    import wcb_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_open,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [WSEL_W-1:0]     wr_word,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [WORD_BYTES-1:0] wr_be,
    input  logic                  clr,
    output logic                  occ,
    output logic [TAG_W-1:0]      tag,
    output logic [LINE_BYTES-1:0] mask,
    output logic [LINE_W-1:0]     data,
    output logic                  full
);
    line_t cur, merged;

    assign cur    = '{mask: mask, data: data};
    assign merged = merge_word(cur, wr_word, wr_data, wr_be);

    // Valid flags and tag: set by merges, cleared on bus acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            tag  <= '0;
        end else if (clr) begin
            mask <= '0;
            tag  <= '0;
        end else if (wr_en) begin
            mask <= merged.mask;
            if (wr_open) tag <= wr_tag;
        end
    end

    // Line data: newest bytes overwrite older ones.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) data <= merged.data;
    end

    assign occ  = |mask;
    assign full = &mask;
endmodule

// File: rtl/wcb_age.sv
// Tracks the order in which buffers were opened, as a rank per buffer
// (0 = oldest occupied). Assumes opens use a free buffer and clears an
// occupied one.
module wcb_age #(
    parameter int NUM_BUF = 4,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] occ,
    input  logic               open_en,
    input  logic [IDX_W-1:0]   open_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [IDX_W-1:0]   oldest_idx
);
    logic [IDX_W-1:0] rank [NUM_BUF];
    logic [IDX_W-1:0] new_rank;

    // Rank for a newly opened buffer: occupied count after any same-cycle clear.
    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < NUM_BUF; i++) cnt += int'(occ[i]);
        if (clr_en) cnt -= 1;
        new_rank = IDX_W'(cnt);
    end

    // Rank upkeep: assign on open, close the gap on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) rank[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BUF; i++) begin
                if (clr_en && clr_idx == IDX_W'(i))
                    rank[i] <= '0;
                else if (open_en && open_idx == IDX_W'(i))
                    rank[i] <= new_rank;
                else if (clr_en && occ[i] && rank[i] > rank[clr_idx])
                    rank[i] <= rank[i] - 1'b1;
            end
        end
    end

    // Oldest occupied buffer is the one holding rank zero.
    always_comb begin
        oldest_idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--)
            if (occ[i] && rank[i] == '0) oldest_idx = IDX_W'(i);
    end
endmodule

// File: rtl/wcb_drain_sel.sv
// Chooses the next buffer to offer on the bus. Full lines go first (lowest
// index), then the oldest line when a flush or an eviction needs one.
// Assumes it is consulted only while no write is pending.
module wcb_drain_sel #(
    parameter int NUM_BUF = 4,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               idle,
    input  logic [NUM_BUF-1:0] occ,
    input  logic [NUM_BUF-1:0] full_vec,
    input  logic [IDX_W-1:0]   oldest_idx,
    input  logic               flush_pend,
    input  logic               need_evict,
    output logic               start,
    output logic [IDX_W-1:0]   sel_idx
);
    // Priority pick of the drain candidate.
    always_comb begin
        start   = 1'b0;
        sel_idx = oldest_idx;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (full_vec[i]) begin
                start   = idle;
                sel_idx = IDX_W'(i);
            end
        end
        if (!(|full_vec) && (flush_pend || need_evict) && (|occ))
            start = idle;
    end
endmodule

// File: rtl/wcb_store_buffer.sv
// Write-combining store buffer top. Stores merge into per-line buffers;
// buffers drain as byte-masked line writes on a valid/ready bus port when
// full, when evicted for a new line, or on flush. One write in flight.
// Assumes st_be/st_data stable while st_valid waits for st_ready.
module wcb_store_buffer
    import wcb_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int TAG_W  = ADDR_W - OFS_W,
    localparam int WA_W   = ADDR_W - WORD_OFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [WA_W-1:0]       st_waddr,
    input  logic [WORD_W-1:0]     st_data,
    input  logic [WORD_BYTES-1:0] st_be,
    input  logic                  flush_req,
    output logic                  flush_done,
    output logic                  bw_valid,
    input  logic                  bw_ready,
    output logic [ADDR_W-1:0]     bw_addr,
    output logic [LINE_W-1:0]     bw_data,
    output logic [LINE_BYTES-1:0] bw_mask,
    output logic                  bw_full
);
    logic [TAG_W-1:0]      st_tag;
    logic [WSEL_W-1:0]     st_word;
    logic [NUM_BUF-1:0]    occ, full_vec, wr_en, clr;
    logic [TAG_W-1:0]      tag_a  [NUM_BUF];
    logic [LINE_BYTES-1:0] mask_a [NUM_BUF];
    logic [LINE_W-1:0]     data_a [NUM_BUF];
    logic                  hit_any, free_any, hit_busy, be_zero, acc, need_evict;
    logic [IDX_W-1:0]      hit_idx, free_idx, oldest_idx, sel_idx, drain_idx_q;
    logic                  bw_valid_q, flush_pend_q, flush_done_q, start, accept, all_idle;

    assign st_tag  = st_waddr[WA_W-1:WSEL_W];
    assign st_word = st_waddr[WSEL_W-1:0];

    // Tag lookup and free-slot search, lowest index wins.
    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (occ[i] && tag_a[i] == st_tag) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!occ[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Store admission: hold during flush, on a line being offered, or when full.
    always_comb begin
        be_zero    = (st_be == '0);
        hit_busy   = hit_any && bw_valid_q && (drain_idx_q == hit_idx);
        st_ready   = !flush_pend_q && (be_zero || (hit_any ? !hit_busy : free_any));
        acc        = st_valid && st_ready && !be_zero;
        need_evict = st_valid && !be_zero && !hit_any && !free_any && !flush_pend_q;
        accept     = bw_valid_q && bw_ready;
        all_idle   = !(|occ) && !bw_valid_q;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_BUF; g++) begin : g_buf
            assign wr_en[g] = acc && ((hit_any ? hit_idx : free_idx) == IDX_W'(g));
            assign clr[g]   = accept && (drain_idx_q == IDX_W'(g));
            wcb_line #(.TAG_W(TAG_W)) u_line (
                .clk(clk), .rst_n(rst_n),
                .wr_en(wr_en[g]), .wr_open(!hit_any), .wr_tag(st_tag),
                .wr_word(st_word), .wr_data(st_data), .wr_be(st_be),
                .clr(clr[g]),
                .occ(occ[g]), .tag(tag_a[g]), .mask(mask_a[g]),
                .data(data_a[g]), .full(full_vec[g])
            );
        end
    endgenerate

    wcb_age #(.NUM_BUF(NUM_BUF)) u_age (
        .clk(clk), .rst_n(rst_n), .occ(occ),
        .open_en(acc && !hit_any), .open_idx(free_idx),
        .clr_en(accept), .clr_idx(drain_idx_q),
        .oldest_idx(oldest_idx)
    );

    wcb_drain_sel #(.NUM_BUF(NUM_BUF)) u_sel (
        .idle(!bw_valid_q), .occ(occ), .full_vec(full_vec),
        .oldest_idx(oldest_idx), .flush_pend(flush_pend_q),
        .need_evict(need_evict), .start(start), .sel_idx(sel_idx)
    );

    // Bus write slot: launch a selected buffer, retire on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_valid_q  <= 1'b0;
            drain_idx_q <= '0;
        end else if (accept) begin
            bw_valid_q  <= 1'b0;
        end else if (start) begin
            bw_valid_q  <= 1'b1;
            drain_idx_q <= sel_idx;
        end
    end

    // Flush tracking: pending until everything is empty, then a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_pend_q <= 1'b0;
            flush_done_q <= 1'b0;
        end else begin
            flush_done_q <= flush_pend_q && all_idle;
            flush_pend_q <= flush_req || (flush_pend_q && !all_idle);
        end
    end

    assign bw_valid   = bw_valid_q;
    assign bw_addr    = {tag_a[drain_idx_q], {OFS_W{1'b0}}};
    assign bw_data    = data_a[drain_idx_q];
    assign bw_mask    = mask_a[drain_idx_q];
    assign bw_full    = &mask_a[drain_idx_q];
    assign flush_done = flush_done_q;
endmodule

// File: rtl/wcb_store_buffer_chk.sv
// Port-level protocol checks for wcb_store_buffer, attached by bind.
module wcb_store_buffer_chk
    import wcb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_ready,
    input logic                  flush_req,
    input logic                  flush_done,
    input logic                  bw_valid,
    input logic                  bw_ready,
    input logic [ADDR_W-1:0]     bw_addr,
    input logic [LINE_W-1:0]     bw_data,
    input logic [LINE_BYTES-1:0] bw_mask,
    input logic                  bw_full
);
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid && !bw_ready |=> bw_valid && $stable(bw_addr) && $stable(bw_mask) && $stable(bw_data)); // R8
    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> bw_addr[OFS_W-1:0] == '0); // R11
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid && bw_full |-> &bw_mask); // R4
    AST_NONEMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> |bw_mask); // R5
    AST_FLUSH_HOLDS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !st_ready); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !bw_valid); // R7
endmodule

bind wcb_store_buffer wcb_store_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .flush_req(flush_req),
    .flush_done(flush_done), .bw_valid(bw_valid), .bw_ready(bw_ready),
    .bw_addr(bw_addr), .bw_data(bw_data), .bw_mask(bw_mask), .bw_full(bw_full)
);

// File: tb/tb_wcb_store_buffer.sv
`timescale 1ns/1ps
module tb_wcb_store_buffer;
    localparam int ADDR_W = 32;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         st_valid = 1'b0, st_ready;
    logic [28:0]  st_waddr = '0;
    logic [63:0]  st_data = '0;
    logic [7:0]   st_be = '0;
    logic         flush_req = 1'b0, flush_done;
    logic         bw_valid, bw_ready = 1'b1, bw_full;
    logic [31:0]  bw_addr;
    logic [511:0] bw_data;
    logic [63:0]  bw_mask;

    wcb_store_buffer #(.NUM_BUF(4), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be),
        .flush_req(flush_req), .flush_done(flush_done),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
        .bw_data(bw_data), .bw_mask(bw_mask), .bw_full(bw_full)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    // Reference model: pending bytes per line and opening order.
    logic [63:0]  pmask [int unsigned];
    logic [511:0] pdata [int unsigned];
    int unsigned  order_q[$];
    int           n_writes = 0;
    int unsigned  last_wr_line = 0;
    logic [63:0]  last_wr_mask = '0;
    bit           tb_flushing = 0, mon_on = 0;
    bit           ready_rand = 0, ready_force = 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) bw_ready <= ready_rand ? ($urandom_range(0, 3) != 0) : ready_force;

    // Monitor: samples 1 ns after the falling edge, compares with the model.
    initial forever begin
        @(negedge clk); #1;
        if (mon_on) begin
            if (bw_valid && bw_ready) begin
                int unsigned line;
                logic [63:0] em;
                int bad;
                line = bw_addr >> 6;
                em = pmask.exists(line) ? pmask[line] : 64'h0;
                bad = -1;
                check(bw_mask == em, "R5", "write mask", bw_mask, em);
                check(bw_addr[5:0] == 6'd0, "R11", "address alignment", bw_addr, {bw_addr[31:6], 6'd0});
                check(bw_full == (&em), "R4", "full flag", bw_full, &em);
                for (int n = 0; n < 64; n++)
                    if (em[n] && pdata.exists(line) && bw_data[n*8 +: 8] !== pdata[line][n*8 +: 8] && bad < 0) bad = n;
                if (bad >= 0) check(0, "R3", "newest byte value", bw_data[bad*8 +: 8], pdata[line][bad*8 +: 8]);
                else check(1, "R3", "newest byte value", 0, 0);
                if (!bw_full && !tb_flushing)
                    check(order_q.size() > 0 && order_q[0] == line, "R6", "eviction picks oldest line",
                          line, order_q.size() > 0 ? order_q[0] : 0);
                for (int k = 0; k < order_q.size(); k++)
                    if (order_q[k] == line) begin order_q.delete(k); break; end
                pmask.delete(line);
                pdata.delete(line);
                n_writes++;
                last_wr_line = line;
                last_wr_mask = bw_mask;
            end
            if (st_valid && st_ready && st_be != 8'h0) begin
                int unsigned line;
                int word;
                line = st_waddr >> 3;
                word = int'(st_waddr[2:0]);
                if (!pmask.exists(line)) begin
                    pmask[line] = '0;
                    pdata[line] = '0;
                    order_q.push_back(line);
                end
                for (int b = 0; b < 8; b++)
                    if (st_be[b]) begin
                        pmask[line][word*8 + b] = 1'b1;
                        pdata[line][(word*8 + b)*8 +: 8] = st_data[b*8 +: 8];
                    end
            end
            if (flush_done)
                check(pmask.num() == 0, "R7", "empty at flush done", pmask.num(), 0);
        end
    end

    task automatic do_store(input int unsigned line, input int word, input logic [63:0] d,
                            input logic [7:0] be, output int waits);
        @(negedge clk);
        st_valid = 1'b1;
        st_waddr = 29'((line << 3) | word);
        st_data  = d;
        st_be    = be;
        waits    = 0;
        forever begin
            #1;
            if (st_ready) begin @(negedge clk); break; end
            waits++;
            @(negedge clk);
        end
        st_valid = 1'b0;
    endtask

    task automatic do_flush();
        int w;
        @(negedge clk);
        flush_req   = 1'b1;
        tb_flushing = 1;
        @(negedge clk);
        flush_req = 1'b0;
        #1;
        check(!st_ready, "R7", "stores held during flush", st_ready, 0);
        w = 0;
        while (!flush_done && w < 3000) begin @(negedge clk); #1; w++; end
        check(flush_done, "R7", "flush completes", flush_done, 1);
        tb_flushing = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w, n0;
        logic [31:0] hold_addr;
        logic [63:0] hold_mask;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk); #1;
        check(st_ready == 1'b1, "R1", "ready after reset", st_ready, 1);
        check(bw_valid == 1'b0, "R1", "no write after reset", bw_valid, 0);
        check(flush_done == 1'b0, "R1", "done low after reset", flush_done, 0);

        // R2 and R3: merge and overlap on one line.
        n0 = n_writes;
        do_store(32'h100, 0, 64'h1111_2222_3333_4444, 8'h0F, w);
        do_store(32'h100, 0, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, w);
        do_store(32'h100, 5, 64'h0123_4567_89AB_CDEF, 8'hFF, w);
        do_flush();
        check(n_writes == n0 + 1, "R2", "one write per merged line", n_writes - n0, 1);

        // R4: a complete line leaves by itself.
        n0 = n_writes;
        for (int k = 0; k < 8; k++) do_store(32'h200, k, {32'hF00D0000 | k, 32'h5A5A5A5A}, 8'hFF, w);
        for (int k = 0; k < 10 && n_writes == n0; k++) begin @(negedge clk); #1; end
        check(n_writes == n0 + 1 && last_wr_line == 32'h200, "R4", "full line drains unprompted", last_wr_line, 32'h200);

        // R6: all buffers taken, a fifth line evicts the oldest.
        for (int k = 0; k < 4; k++) do_store(32'h10 + k, k, 64'hC0DE_0000_0000_0000 | k, 8'h81, w);
        do_store(32'h14, 1, 64'h7777_7777_7777_7777, 8'h0F, w);
        check(w > 0, "R6", "new line waits for a free buffer", w, 1);
        check(last_wr_line == 32'h10, "R6", "oldest line evicted", last_wr_line, 32'h10);
        do_flush();

        // R9: zero byte enables leave no trace.
        n0 = n_writes;
        do_store(32'h20, 3, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, w);
        do_flush();
        check(n_writes == n0, "R9", "zero-enable store writes nothing", n_writes - n0, 0);

        // R10 and R8: store to the line parked on a stalled bus.
        ready_force = 0;
        for (int k = 0; k < 8; k++) do_store(32'h30, k, 64'hBEEF_0000_0000_0000 | k, 8'hFF, w);
        repeat (3) @(negedge clk); #1;
        check(bw_valid && bw_full, "R4", "full line offered", bw_valid, 1);
        hold_addr = bw_addr;
        hold_mask = bw_mask;
        fork
            do_store(32'h30, 2, 64'h9999_8888_7777_6666, 8'hFF, w);
            begin
                repeat (4) @(negedge clk); #1;
                check(!st_ready, "R10", "store to parked line held", st_ready, 0);
                check(bw_addr == hold_addr && bw_mask == hold_mask, "R8", "parked write stable", bw_addr, hold_addr);
                ready_force = 1;
            end
        join
        check(w > 0, "R10", "store waited for acceptance", w, 1);
        do_flush();
        check(last_wr_line == 32'h30 && last_wr_mask == 64'h0000_0000_00FF_0000, "R8",
              "reopened line holds only new bytes", last_wr_mask, 64'h0000_0000_00FF_0000);

        // Random traffic with random bus back-pressure.
        ready_rand = 1;
        for (int n = 0; n < 1500; n++) begin
            do_store(32'h40 + $urandom_range(0, 5), $urandom_range(0, 7),
                     {$urandom, $urandom}, 8'($urandom_range(0, 255)), w);
            if (n % 97 == 96) do_flush();
        end
        do_flush();
        check(pmask.num() == 0, "R7", "model empty at end", pmask.num(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule